// File: doc/BRIEF.md
# Trimmable One-Second Prescaler

This block turns a slow timekeeping clock, nominally 32768 cycles per second, into a one-second strobe. The length of each second is programmable so that firmware can correct a crystal that runs fast or slow. A 16-bit trim word sets the period: one second lasts the trim word plus one input cycles. The reset value 0x7FFF gives exactly 32768 cycles, which is zero correction. A larger trim word lengthens the second, so the clock runs slower. A smaller trim word shortens the second.

The trim word comes from one of two sources. One is a software-written value. The other is the result of a hardware measurement against a reference clock. That measurement is outside this block and arrives as a plain input word. The hardware word is used only when the hardware source is selected and hardware trimming is armed. The block also outputs the trim word that governs the current second, so a status register can show it.

A trim change never cuts a running second short. The counter captures the selected word only at a second boundary, or at any cycle while the block is stopped. While stopped, the counter rests at zero. The first strobe after a start therefore arrives exactly one full period later.

Top module: `sec_prescaler`

## Requirements
- R1: During and directly after reset, `sec_tick` is 0 and `cal_in_use` is 0x7FFF.
- R2: While running with a fixed trim word W, consecutive strobes are exactly W+1 clock cycles apart. The reset default gives a period of 32768 cycles.
- R3: `sec_tick` is high for exactly one clock cycle per second whenever W is nonzero.
- R4: The selected trim word is `hw_cal` when both `cal_src_hw` = 1 and `cal_hw_en` = 1. In every other combination of these two inputs it is `sw_cal`.
- R5: A change of the selected trim word while running does not alter the second in progress. The new word governs the period that starts at the next strobe.
- R6: While `run_en` = 0 the counter is held at zero and no strobe occurs. After `run_en` rises, the first strobe appears exactly W+1 cycles later.
- R7: `cal_in_use` shows the trim word of the current second. It changes only in the cycle of a strobe or while stopped. While stopped it follows the selected word one cycle later.
- R8: The extreme trim words work: W = 0 gives a strobe on every cycle, and W = 0xFFFF gives a period of 65536 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timekeeping clock, nominally 32768 cycles per second |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Runs the prescaler. When 0, the count is held at zero |
| cal_hw_en | input | 1 | Arms hardware trimming |
| cal_src_hw | input | 1 | Source select: 0 selects software, 1 selects hardware |
| sw_cal | input | 16 | Software-written trim word |
| hw_cal | input | 16 | Trim word from the hardware measurement |
| sec_tick | output | 1 | One-cycle strobe at each second boundary |
| cal_in_use | output | 16 | Trim word governing the current second |

## Verification
The checker watches several rules on every cycle:
- the count never passes the active trim word;
- a stopped block has a zero count and no strobe;
- the reported trim word only moves at a boundary or while stopped, and while stopped it follows the selected source;
- a strobe is never followed by another unless the word is zero.

Other properties can only be shown by the bench's scenarios, which measure whole periods:
- the exact period lengths, including 32768 and 65536;
- that a mid-second change leaves the running second untouched;
- that the first second after a restart is complete.

// File: rtl/sec_prescaler_pkg.sv
package sec_prescaler_pkg;

    typedef enum logic {
        SRC_SOFT = 1'b0,
        SRC_HARD = 1'b1
    } trim_src_e;

    typedef struct packed {
        logic      run;
        logic      hw_armed;
        trim_src_e src;
    } pre_cfg_t;

    // Hardware word only when its source is chosen and trimming is armed
    function automatic logic use_hard(input pre_cfg_t cfg);
        return (cfg.src == SRC_HARD) && cfg.hw_armed;
    endfunction

    // Nominal trim word for a counter of the given width: half range minus one
    function automatic int unsigned nominal_trim(input int unsigned width);
        return (32'd1 << (width - 1)) - 32'd1;
    endfunction

endpackage

// File: rtl/trim_source_mux.sv
module trim_source_mux
    import sec_prescaler_pkg::*;
#(
    parameter int unsigned CAL_W = 16
) (
    input  pre_cfg_t         cfg,
    input  logic [CAL_W-1:0] soft_word,
    input  logic [CAL_W-1:0] hard_word,
    output logic [CAL_W-1:0] chosen_word
);

    always_comb begin
        if (use_hard(cfg)) begin
            chosen_word = hard_word;
        end else begin
            chosen_word = soft_word;
        end
    end

endmodule

// File: rtl/second_counter.sv
module second_counter #(
    parameter int unsigned CAL_W     = 16,
    parameter int unsigned RESET_LIM = 32767
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CAL_W-1:0] next_lim,
    output logic [CAL_W-1:0] count,
    output logic [CAL_W-1:0] limit,
    output logic             tick
);

    localparam logic [CAL_W-1:0] LIM_INIT = CAL_W'(RESET_LIM);

    logic [CAL_W-1:0] cnt_q;
    logic [CAL_W-1:0] lim_q;
    logic             tick_q;
    logic             at_end;

    assign at_end = (cnt_q == lim_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            lim_q  <= LIM_INIT;
            tick_q <= 1'b0;
        end else if (!run) begin
            // stopped: rest at zero and track the selected word
            cnt_q  <= '0;
            lim_q  <= next_lim;
            tick_q <= 1'b0;
        end else if (at_end) begin
            // boundary: close the second and adopt the new word
            cnt_q  <= '0;
            lim_q  <= next_lim;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign count = cnt_q;
    assign limit = lim_q;
    assign tick  = tick_q;

endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler
    import sec_prescaler_pkg::*;
#(
    parameter int unsigned CAL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             cal_hw_en,
    input  logic             cal_src_hw,
    input  logic [CAL_W-1:0] sw_cal,
    input  logic [CAL_W-1:0] hw_cal,
    output logic             sec_tick,
    output logic [CAL_W-1:0] cal_in_use
);

    localparam int unsigned DEF_TRIM = nominal_trim(CAL_W);

    pre_cfg_t         cfg;
    logic [CAL_W-1:0] chosen;
    logic [CAL_W-1:0] sec_count;

    assign cfg.run      = run_en;
    assign cfg.hw_armed = cal_hw_en;
    assign cfg.src      = cal_src_hw ? SRC_HARD : SRC_SOFT;

    trim_source_mux #(
        .CAL_W(CAL_W)
    ) u_mux (
        .cfg        (cfg),
        .soft_word  (sw_cal),
        .hard_word  (hw_cal),
        .chosen_word(chosen)
    );

    second_counter #(
        .CAL_W    (CAL_W),
        .RESET_LIM(DEF_TRIM)
    ) u_count (
        .clk     (clk),
        .rst     (rst),
        .run     (cfg.run),
        .next_lim(chosen),
        .count   (sec_count),
        .limit   (cal_in_use),
        .tick    (sec_tick)
    );

endmodule

// File: rtl/sec_prescaler_chk.sv
module sec_prescaler_chk #(
    parameter int unsigned CAL_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run_en,
    input logic             cal_hw_en,
    input logic             cal_src_hw,
    input logic [CAL_W-1:0] sw_cal,
    input logic [CAL_W-1:0] hw_cal,
    input logic             sec_tick,
    input logic [CAL_W-1:0] cal_in_use,
    input logic [CAL_W-1:0] count
);

    logic [CAL_W-1:0] want_word;
    assign want_word = (cal_src_hw && cal_hw_en) ? hw_cal : sw_cal;

    // R2
    count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        count <= cal_in_use);

    // R3
    single_cycle_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && cal_in_use != '0) |=> !sec_tick);

    // R6
    stopped_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (count == '0 && !sec_tick));

    // R5
    word_held_mid_second_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(run_en) && !$past(rst) && !sec_tick) |-> $stable(cal_in_use));

    // R4
    stopped_follows_source_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> cal_in_use == $past(want_word));

endmodule

bind sec_prescaler sec_prescaler_chk #(.CAL_W(CAL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .cal_hw_en (cal_hw_en),
    .cal_src_hw(cal_src_hw),
    .sw_cal    (sw_cal),
    .hw_cal    (hw_cal),
    .sec_tick  (sec_tick),
    .cal_in_use(cal_in_use),
    .count     (sec_count)
);

// File: tb/sec_prescaler_tb.sv
module sec_prescaler_tb;

    localparam int W = 16;
    localparam int WATCHDOG = 190000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         run_en = 1'b0;
    logic         cal_hw_en = 1'b0;
    logic         cal_src_hw = 1'b0;
    logic [W-1:0] sw_cal = 16'h7FFF;
    logic [W-1:0] hw_cal = 16'h0000;
    logic         sec_tick;
    logic [W-1:0] cal_in_use;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    sec_prescaler #(.CAL_W(W)) u_dut (
        .clk(clk), .rst(rst), .run_en(run_en), .cal_hw_en(cal_hw_en),
        .cal_src_hw(cal_src_hw), .sw_cal(sw_cal), .hw_cal(hw_cal),
        .sec_tick(sec_tick), .cal_in_use(cal_in_use)
    );

    function automatic int exp_word(input bit src, input bit arm,
                                    input int sw, input int hw);
        return (src && arm) ? hw : sw;
    endfunction

    function automatic int exp_period(input int word);
        return word + 1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_tick(input int pre, output int n);
        n = pre;
        do begin
            @(negedge clk);
            n++;
        end while (!sec_tick && n < 70000);
    endtask

    task automatic stop_and_load(input bit src, input bit arm, input int sw, input int hw);
        @(negedge clk);
        run_en = 1'b0; cal_src_hw = src; cal_hw_en = arm;
        sw_cal = W'(sw); hw_cal = W'(hw);
        @(negedge clk);
    endtask

    initial begin
        int n;
        int w;
        int seed;
        seed = $urandom(32'd4242);

        repeat (3) @(negedge clk);
        check(sec_tick == 1'b0, "R1", "tick in reset", sec_tick, 0);
        check(cal_in_use == 16'h7FFF, "R1", "word in reset", cal_in_use, 32767);
        rst = 1'b0;
        @(negedge clk);
        check(cal_in_use == 16'h7FFF, "R1", "word after reset", cal_in_use, 32767);

        // R2 / R6: default period from a fresh start
        run_en = 1'b1;
        wait_tick(0, n);
        check(n == 32768, "R2", "default period", n, 32768);
        check(cal_in_use == 16'h7FFF, "R7", "default word", cal_in_use, 32767);

        // R8: zero word ticks every cycle
        stop_and_load(0, 0, 0, 0);
        run_en = 1'b1;
        wait_tick(0, n);
        check(n == 1, "R8", "zero word first", n, 1);
        @(negedge clk);
        check(sec_tick == 1'b1, "R8", "zero word repeat", sec_tick, 1);

        // R4: source selection seen while stopped
        stop_and_load(1, 1, 5, 7);
        check(cal_in_use == 7, "R4", "hw selected", cal_in_use, exp_word(1, 1, 5, 7));
        stop_and_load(1, 0, 5, 7);
        check(cal_in_use == 5, "R4", "hw not armed", cal_in_use, exp_word(1, 0, 5, 7));
        stop_and_load(0, 1, 5, 7);
        check(cal_in_use == 5, "R4", "sw selected", cal_in_use, exp_word(0, 1, 5, 7));
        stop_and_load(1, 1, 5, 7);
        run_en = 1'b1;
        wait_tick(0, n);
        check(n == exp_period(7), "R4", "hw period", n, exp_period(7));

        // R5: mid-second change waits for the boundary
        stop_and_load(0, 0, 9, 0);
        run_en = 1'b1;
        wait_tick(0, n);
        check(n == 10, "R5", "first second", n, 10);
        repeat (3) @(negedge clk);
        sw_cal = 16'd3;
        @(negedge clk);
        check(cal_in_use == 9, "R7", "word kept mid second", cal_in_use, 9);
        wait_tick(4, n);
        check(n == 10, "R5", "second not shortened", n, 10);
        check(cal_in_use == 3, "R7", "word after boundary", cal_in_use, 3);
        wait_tick(0, n);
        check(n == 4, "R5", "new period", n, 4);

        // R6: stop mid-second, stay quiet, restart gives a full period
        sw_cal = 16'd20;
        wait_tick(0, n);
        repeat (6) @(negedge clk);
        run_en = 1'b0;
        n = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (sec_tick) n++;
        end
        check(n == 0, "R6", "ticks while stopped", n, 0);
        run_en = 1'b1;
        wait_tick(0, n);
        check(n == 21, "R6", "restart period", n, 21);

        // R3 / R2: random words and sources
        for (int k = 0; k < 10; k++) begin
            bit s, a;
            int sw, hw;
            s = 1'($urandom());
            a = 1'($urandom());
            sw = 1 + int'($urandom_range(300));
            hw = 1 + int'($urandom_range(300));
            w = exp_word(s, a, sw, hw);
            stop_and_load(s, a, sw, hw);
            run_en = 1'b1;
            wait_tick(0, n);
            check(n == exp_period(w), "R2", "random first period", n, exp_period(w));
            @(negedge clk);
            check(sec_tick == 1'b0, "R3", "tick width", sec_tick, 0);
            wait_tick(1, n);
            check(n == exp_period(w), "R2", "random period", n, exp_period(w));
        end

        // R8: largest word
        stop_and_load(0, 0, 16'hFFFF, 0);
        check(cal_in_use == 16'hFFFF, "R8", "max word", cal_in_use, 65535);
        run_en = 1'b1;
        wait_tick(0, n);
        check(n == 65536, "R8", "max period", n, 65536);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles >= WATCHDOG);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule